// File: doc/BRIEF.md
# Redundant Reference Clock Monitor with Automatic Switchover

This block sits beside a clock generator that has two redundant reference inputs. It samples both references in the domain of a feedback clock and watches each one for activity. If a reference stops toggling long enough, stuck either high or low, the block raises a bad flag for it. The flag stays set until software or a board-level control pulses the alarm-clear input.

The block also decides which reference is in use. If the active reference fails while the other one is still healthy, the selection moves to the healthy one on its own. A falling edge on the alarm-clear input clears both flags and sets the selection back to the value of the select pin. With the override pin high, the selection follows the select pin directly and no automatic move takes place. All pins are synchronized into the feedback domain. The master reset acts on the block as soon as it is asserted, and its release is synchronized to the feedback clock.

Top module: `refclk_guard`

## Requirements
- R1: While the master reset `rst_n` is low, `bad0`, `bad1` and `active_sel` are all 0. This takes effect without waiting for a clock edge.
- R2: A reference that changes level at least once every feedback cycle never raises its bad flag.
- R3: A reference held high, or held low, for `TIMEOUT` feedback cycles after synchronization raises its flag. A reference that has been quiet for only 2 cycles does not.
- R4: A bad flag stays at 1 once set, even after its reference starts toggling again, until an alarm clear occurs.
- R5: If the selected reference is flagged and the other is not, `active_sel` switches to the other reference (0 means reference 0, 1 means reference 1). A failure of the unselected reference leaves `active_sel` unchanged.
- R6: A falling edge on `alarm_clr_n` clears both flags and loads `active_sel` from `sel_pin`.
- R7: The alarm clear acts only once per falling edge. A reference that fails while `alarm_clr_n` is still held low is flagged as usual.
- R8: While both flags are set, `active_sel` holds its value.
- R9: While `ovr_pin` is 1, `active_sel` follows `sel_pin` and a flagged selected reference causes no switch. Flags are still raised.
- R10: The outputs reset asynchronously when `rst_n` falls in the middle of a clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Feedback clock, the timing base of the monitor |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| ref0 | input | 1 | Reference clock 0 |
| ref1 | input | 1 | Reference clock 1 |
| sel_pin | input | 1 | Requested reference: 0 selects ref0, 1 selects ref1 |
| ovr_pin | input | 1 | 1 disables automatic switching |
| alarm_clr_n | input | 1 | Active-low alarm clear, acts on its falling edge |
| bad0 | output | 1 | Sticky failure flag for ref0 |
| bad1 | output | 1 | Sticky failure flag for ref1 |
| active_sel | output | 1 | Reference in use: 0 is ref0, 1 is ref1 |

## Verification
The bench targets the following corner cases:

- **Stuck high and stuck low.** Both are driven. A design that only detects one of the two polarities leaves the flag clear.
- **Recovery after a failure.** The failed reference is brought back to toggling. A design whose flag is not sticky would drop it, and a design that switches back would change the selection.
- **Alarm held low.** The alarm input is held low while a second reference fails. A level-sensitive clear would hide that failure.
- **Double failure.** Both references are failed in turn. A design that switches on every failure would move the selection onto a dead input.
- **Override.** Override is exercised with a flagged selected reference, which catches a design that still switches on its own.
- **Asynchronous reset.** A reset asserted between clock edges catches a design whose reset is synchronous.

// File: rtl/refguard_pkg.sv
package refguard_pkg;
  typedef enum logic {
    SEL_REF0 = 1'b0,
    SEL_REF1 = 1'b1
  } ref_sel_e;

  localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/rg_reset_sync.sv
module rg_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/rg_ref_watch.sv
module rg_ref_watch #(
  parameter int unsigned TIMEOUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_raw,
  input  logic clr,
  output logic bad
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] SAT  = CW'(TIMEOUT);

  logic          ref_s;
  logic          ref_prev_q;
  logic          edge_w;
  logic          expire_w;
  logic          cnt_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bad_q, bad_d;

  rg_sync #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ref_raw),
    .q     (ref_s)
  );

  always_comb begin
    edge_w   = ref_s ^ ref_prev_q;
    expire_w = !edge_w && (cnt_q == LAST);
    cnt_en   = clr || edge_w || (cnt_q != SAT);
    cnt_d    = cnt_q;
    if (clr || edge_w)      cnt_d = '0;
    else if (cnt_q != SAT)  cnt_d = cnt_q + 1'b1;
    bad_d = bad_q;
    if (clr)           bad_d = 1'b0;
    else if (expire_w) bad_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      cnt_q      <= '0;
      bad_q      <= 1'b0;
    end else begin
      ref_prev_q <= ref_s;
      if (cnt_en) cnt_q <= cnt_d;
      bad_q <= bad_d;
    end
  end

  assign bad = bad_q;

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !clr) |=> bad_q);
  a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !bad_q);
  a_r2_edge_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> !$rose(bad_q));
endmodule

// File: rtl/rg_alarm_edge.sv
module rg_alarm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_n_raw,
  output logic pulse
);
  logic alarm_s;
  logic prev_q;

  rg_sync #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (alarm_n_raw),
    .q     (alarm_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= alarm_s;
  end

  assign pulse = prev_q && !alarm_s;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/rg_sel_ctrl.sv
module rg_sel_ctrl
  import refguard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic ovr_s,
  input  logic clr,
  input  logic bad0,
  input  logic bad1,
  output logic cur
);
  ref_sel_e cur_q, cur_d;
  logic     cur_bad, oth_bad;

  always_comb begin
    cur_bad = (cur_q == SEL_REF1) ? bad1 : bad0;
    oth_bad = (cur_q == SEL_REF1) ? bad0 : bad1;
    cur_d   = cur_q;
    if (ovr_s || clr)
      cur_d = sel_s ? SEL_REF1 : SEL_REF0;
    else if (cur_bad && !oth_bad)
      cur_d = (cur_q == SEL_REF0) ? SEL_REF1 : SEL_REF0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= SEL_REF0;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;

  a_r8_double_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_s && !clr && bad0 && bad1) |=> $stable(cur_q));
  a_r9_follow_pin: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_s |=> (cur_q == ($past(sel_s) ? SEL_REF1 : SEL_REF0)));
  a_r5_failover: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_s && !clr && cur_bad && !oth_bad) |=> (cur_q != $past(cur_q)));
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard #(
  parameter int unsigned TIMEOUT = 4
) (
  input  logic fb_clk,
  input  logic rst_n,
  input  logic ref0,
  input  logic ref1,
  input  logic sel_pin,
  input  logic ovr_pin,
  input  logic alarm_clr_n,
  output logic bad0,
  output logic bad1,
  output logic active_sel
);
  import refguard_pkg::*;

  logic                rst_int_n;
  logic [NUM_REFS-1:0] ref_raw;
  logic [NUM_REFS-1:0] bad_w;
  logic [1:0]          ctl_s;
  logic                clr_pulse;

  assign ref_raw = {ref1, ref0};

  rg_reset_sync u_rst (
    .clk     (fb_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  rg_sync #(.W(2), .RST_VAL(2'b00)) u_ctl_sync (
    .clk   (fb_clk),
    .rst_n (rst_int_n),
    .d     ({ovr_pin, sel_pin}),
    .q     (ctl_s)
  );

  rg_alarm_edge u_alarm (
    .clk         (fb_clk),
    .rst_n       (rst_int_n),
    .alarm_n_raw (alarm_clr_n),
    .pulse       (clr_pulse)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_watch
    rg_ref_watch #(.TIMEOUT(TIMEOUT)) u_watch (
      .clk     (fb_clk),
      .rst_n   (rst_int_n),
      .ref_raw (ref_raw[i]),
      .clr     (clr_pulse),
      .bad     (bad_w[i])
    );
  end

  rg_sel_ctrl u_sel (
    .clk   (fb_clk),
    .rst_n (rst_int_n),
    .sel_s (ctl_s[0]),
    .ovr_s (ctl_s[1]),
    .clr   (clr_pulse),
    .bad0  (bad_w[0]),
    .bad1  (bad_w[1]),
    .cur   (active_sel)
  );

  assign bad0 = bad_w[0];
  assign bad1 = bad_w[1];

  a_r1_reset_quiet: assert property (@(posedge fb_clk)
    !rst_n |-> (!bad0 && !bad1 && !active_sel));
endmodule

// File: tb/tb_refclk_guard.sv
module tb_refclk_guard;
  logic fb_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref0 = 1'b0, ref1 = 1'b0;
  logic sel_pin = 1'b0, ovr_pin = 1'b0, alarm_clr_n = 1'b1;
  logic bad0, bad1, active_sel;
  int   mode0 = 0, mode1 = 0;
  int   total = 0, fails = 0;

  typedef struct {
    string req;
    logic  b0;
    logic  b1;
    logic  s;
  } exp_t;
  exp_t exp_q[$];

  always #5 fb_clk = ~fb_clk;

  refclk_guard dut (
    .fb_clk(fb_clk), .rst_n(rst_n), .ref0(ref0), .ref1(ref1),
    .sel_pin(sel_pin), .ovr_pin(ovr_pin), .alarm_clr_n(alarm_clr_n),
    .bad0(bad0), .bad1(bad1), .active_sel(active_sel)
  );

  // mode: 0 toggles every cycle, 1 stuck high, 2 stuck low
  always @(negedge fb_clk) begin
    case (mode0)
      0: ref0 <= ~ref0;
      1: ref0 <= 1'b1;
      default: ref0 <= 1'b0;
    endcase
    case (mode1)
      0: ref1 <= ~ref1;
      1: ref1 <= 1'b1;
      default: ref1 <= 1'b0;
    endcase
  end

  task automatic compare(input exp_t e);
    total++;
    if (bad0 !== e.b0 || bad1 !== e.b1 || active_sel !== e.s) begin
      fails++;
      $display("FAIL %s: got bad0=%b bad1=%b sel=%b expected bad0=%b bad1=%b sel=%b",
               e.req, bad0, bad1, active_sel, e.b0, e.b1, e.s);
    end
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge fb_clk) begin
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge fb_clk);
  endtask

  task automatic expect_state(input string req, input logic b0, input logic b1, input logic s);
    exp_t e;
    e.req = req; e.b0 = b0; e.b1 = b1; e.s = s;
    @(negedge fb_clk);
    #1 exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge fb_clk);
  endtask

  task automatic alarm_pulse(input int low_cycles);
    alarm_clr_n = 1'b0;
    cycles(low_cycles);
    alarm_clr_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    exp_t e;
    cycles(3);
    expect_state("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    cycles(20);
    expect_state("R2 healthy", 0, 0, 0);

    mode0 = 1;                       // ref0 stuck high
    cycles(1);
    expect_state("R3 not yet", 0, 0, 0);
    cycles(11);
    expect_state("R3/R5 stuck high failover", 1, 0, 1);

    mode0 = 0;
    cycles(12);
    expect_state("R4 sticky", 1, 0, 1);

    sel_pin = 1'b0;
    alarm_clr_n = 1'b0;
    cycles(8);
    expect_state("R6 clear realign", 0, 0, 0);
    mode1 = 2;                       // ref1 stuck low, alarm still low
    cycles(12);
    expect_state("R7 one-shot / R5 unselected", 0, 1, 0);
    alarm_clr_n = 1'b1;

    mode0 = 2;                       // ref0 stuck low too
    cycles(12);
    expect_state("R8 double hold", 1, 1, 0);

    mode0 = 0; mode1 = 0;
    sel_pin = 1'b1;
    cycles(4);
    alarm_pulse(3);
    cycles(10);
    expect_state("R6 realign to 1", 0, 0, 1);

    ovr_pin = 1'b1; sel_pin = 1'b0;
    cycles(6);
    expect_state("R9 follow pin", 0, 0, 0);
    mode0 = 1;
    cycles(12);
    expect_state("R9 no auto switch", 1, 0, 0);
    sel_pin = 1'b1;
    cycles(6);
    expect_state("R9 pin to 1", 1, 0, 1);
    sel_pin = 1'b0;
    cycles(6);
    expect_state("R9 pin to 0", 1, 0, 0);

    ovr_pin = 1'b0; mode0 = 0; sel_pin = 1'b1;
    cycles(4);
    alarm_pulse(3);
    cycles(10);
    expect_state("R6 clear after override", 0, 0, 1);
    mode1 = 1;
    cycles(12);
    expect_state("R5 failover 1 to 0", 0, 1, 0);

    @(posedge fb_clk);
    #2 rst_n = 1'b0;
    #1;
    e.req = "R10 async reset"; e.b0 = 0; e.b1 = 0; e.s = 0;
    compare(e);
    cycles(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule